// File: doc/BRIEF.md
# Phase-Driven Power Pulsing and Clock Gating Sequencer

This block sits in the digital core of a low-power front-end readout chip. It steps through the operating phases of one machine cycle: acquisition, conversion, a sleep period while the chip waits for its readout turn, readout, and idle. For each phase it sets four power-domain enables, one each for analogue, conversion, threshold DAC and digital logic. The chip spends almost the whole cycle idle and is active for roughly one percent of it, so every domain is switched off whenever its phase does not need it.

The block also controls the fast and slow system clocks and the bias of their receivers. When conversion ends, both clocks are stopped and the receiver bias is removed. An incoming readout-start token wakes them again. After the bias comes on, the block waits a programmable number of slow-clock periods before it opens the clock gates. When readout completes, the block pulses an end-of-readout strobe for the next chip in the chain and returns to idle. An auxiliary receiver enable, for the channel-reset and event-validation inputs, is raised only during acquisition while analogue power is on. Per-domain force bits from slow control hold any domain on or off regardless of phase.

The slow clock is produced by dividing the free-running core clock. Its gate enable is only reloaded while the divided clock is low, so the gated slow clock never shows a shortened pulse.

Top module: `pp_power_sequencer`

## Requirements
- R1: During reset and after it, the phase reads idle (code 0), all four power enables, the receiver bias, both clock enables, the auxiliary receiver enable and the end-of-readout strobe are 0.
- R2: Phase codes are idle=0, acquire=1, convert=2, sleep=3, readout=4. The transitions are: acquisition start moves idle to acquire; acquisition stop moves acquire to convert; conversion done moves convert to sleep; readout start moves idle or sleep to readout; readout done moves readout to idle. The phase output changes on the first clock edge after the input is sampled.
- R3: The power enable bits are bit 0 analogue, bit 1 conversion, bit 2 DAC, bit 3 digital. Without forcing they are: acquire 1101, convert 1010, readout 1000, idle and sleep 0000. They follow the phase one cycle later.
- R4: For each domain, a force-off bit drives the enable to 0, and otherwise a force-on bit drives it to 1. Force-off wins over force-on.
- R5: The auxiliary receiver enable is 1 exactly when the phase is acquire and the effective analogue enable is 1, with the same one-cycle latency as the power enables.
- R6: Clocks are requested in acquire, convert and readout, or whenever the digital domain is forced on. A digital force-off removes the request. The receiver bias rises one cycle after a request. It stays on while either clock enable is set, and it falls once the request is gone and both clock gates have closed.
- R7: After a request starts, neither clock opens until SETTLE slow-clock periods have elapsed. With the defaults (divide by 8, SETTLE 4) both clocks are running no later than 60 core cycles after the request.
- R8: The slow clock has a period of SLOW_DIV core cycles and is high for the first half of each period. Its gate enable changes only while the divided clock is low. While enabled, the gated output toggles with that period, and while disabled it stays at 0.
- R9: Readout done in the readout phase produces a one-cycle end-of-readout pulse on the same edge at which the phase returns to idle.
- R10: An event input outside the phase that accepts it has no effect on the phase or on any enable. Examples are readout start during acquire or convert, and conversion done or readout done in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acq_start_i | input | 1 | Begin acquisition window |
| acq_stop_i | input | 1 | End acquisition window |
| conv_done_i | input | 1 | Conversion finished |
| ro_start_i | input | 1 | Readout token received |
| ro_done_i | input | 1 | Local readout finished |
| force_on_i | input | 4 | Per-domain hold-on bits |
| force_off_i | input | 4 | Per-domain hold-off bits (priority) |
| pwr_en_o | output | 4 | Domain enables: analogue, conversion, DAC, digital |
| rx_bias_en_o | output | 1 | Clock receiver bias enable |
| fast_clk_en_o | output | 1 | Fast clock gate enable |
| slow_clk_en_o | output | 1 | Slow clock gate enable |
| slow_clk_o | output | 1 | Gated divided slow clock |
| aux_rx_en_o | output | 1 | Channel-reset and event-validation receiver enable |
| ro_end_o | output | 1 | End-of-readout strobe |
| phase_o | output | 3 | Current operating phase code |

## Verification
The assertions assume that event inputs are single-cycle strobes and that force bits are held static over many cycles, not toggled every cycle. The settle-window check also assumes that a clock request, once raised, either lasts until the gates open or is dropped cleanly. The bench drives each event as one-cycle pulses at the falling edge. It changes the force bits only between events and leaves at least twenty cycles after each event, so every gate and bias change settles before the next stimulus.

// File: rtl/pp_seq_pkg.sv
package pp_seq_pkg;

   localparam int PP_NUM_DOM = 4;
   localparam int DOM_ANA    = 0;
   localparam int DOM_CONV   = 1;
   localparam int DOM_DAC    = 2;
   localparam int DOM_DIG    = 3;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_ACQ   = 3'd1,
      PH_CONV  = 3'd2,
      PH_SLEEP = 3'd3,
      PH_READ  = 3'd4
   } pp_phase_e;

   // pulsed domain pattern for each phase, bit order follows DOM_* indices
   function automatic logic [PP_NUM_DOM-1:0] phase_domains(pp_phase_e ph);
      logic [PP_NUM_DOM-1:0] m;
      m = '0;
      case (ph)
         PH_ACQ: begin
            m[DOM_ANA] = 1'b1;
            m[DOM_DAC] = 1'b1;
            m[DOM_DIG] = 1'b1;
         end
         PH_CONV: begin
            m[DOM_CONV] = 1'b1;
            m[DOM_DIG]  = 1'b1;
         end
         PH_READ: m[DOM_DIG] = 1'b1;
         default: m = '0;
      endcase
      return m;
   endfunction

   function automatic logic phase_needs_clk(pp_phase_e ph);
      return (ph == PH_ACQ) || (ph == PH_CONV) || (ph == PH_READ);
   endfunction

endpackage

// File: rtl/pp_phase_fsm.sv
module pp_phase_fsm
   import pp_seq_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      acq_start_i,
   input  logic      acq_stop_i,
   input  logic      conv_done_i,
   input  logic      ro_start_i,
   input  logic      ro_done_i,
   output pp_phase_e phase_o,
   output logic      ro_end_o
);

   pp_phase_e ph_q, ph_d;
   logic      end_q;

   always_comb begin
      ph_d = ph_q;
      case (ph_q)
         PH_IDLE: begin
            if (acq_start_i)     ph_d = PH_ACQ;
            else if (ro_start_i) ph_d = PH_READ;
         end
         PH_ACQ:   if (acq_stop_i)  ph_d = PH_CONV;
         PH_CONV:  if (conv_done_i) ph_d = PH_SLEEP;
         PH_SLEEP: if (ro_start_i)  ph_d = PH_READ;
         PH_READ:  if (ro_done_i)   ph_d = PH_IDLE;
         default:  ph_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= PH_IDLE;
         end_q <= 1'b0;
      end else begin
         ph_q  <= ph_d;
         end_q <= (ph_q == PH_READ) && ro_done_i;
      end
   end

   assign phase_o  = ph_q;
   assign ro_end_o = end_q;

   // R2
   legal_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ph_q inside {PH_IDLE, PH_ACQ, PH_CONV, PH_SLEEP, PH_READ});

   // R9
   ro_end_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      end_q |=> !end_q);

   // R9
   ro_end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      end_q |-> (ph_q == PH_IDLE));

endmodule

// File: rtl/pp_domain_ctrl.sv
module pp_domain_ctrl
   import pp_seq_pkg::*;
#(
   parameter int NUM_DOM = PP_NUM_DOM
)(
   input  logic               clk,
   input  logic               rst_n,
   input  pp_phase_e          phase_i,
   input  logic [NUM_DOM-1:0] force_on_i,
   input  logic [NUM_DOM-1:0] force_off_i,
   output logic [NUM_DOM-1:0] en_o,
   output logic               aux_o,
   output logic               clk_req_o
);

   if (NUM_DOM != PP_NUM_DOM) begin : g_bad_dom
      $error("pp_domain_ctrl: NUM_DOM must equal the package domain count");
   end

   logic [NUM_DOM-1:0] pulsed;
   logic [NUM_DOM-1:0] eff;
   logic               aux_q;

   assign pulsed = phase_domains(phase_i);

   for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
      logic q;
      assign eff[d] = !force_off_i[d] && (force_on_i[d] || pulsed[d]);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= 1'b0;
         else        q <= eff[d];
      end
      assign en_o[d] = q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) aux_q <= 1'b0;
      else        aux_q <= eff[DOM_ANA] && (phase_i == PH_ACQ);
   end

   assign aux_o     = aux_q;
   assign clk_req_o = !force_off_i[DOM_DIG] &&
                      (force_on_i[DOM_DIG] || phase_needs_clk(phase_i));

   // R5
   aux_needs_ana_chk: assert property (@(posedge clk) disable iff (!rst_n)
      aux_q |-> en_o[DOM_ANA]);

   // R5
   aux_only_acq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      aux_q |-> $past(phase_i == PH_ACQ));

endmodule

// File: rtl/pp_slow_div.sv
module pp_slow_div #(
   parameter int SLOW_DIV = 8
)(
   input  logic clk,
   input  logic rst_n,
   output logic lvl_o,
   output logic tick_o,
   output logic low_win_o
);

   localparam int CW   = $clog2(SLOW_DIV);
   localparam int HALF = SLOW_DIV / 2;

   if (SLOW_DIV < 4 || (SLOW_DIV % 2) != 0) begin : g_bad_div
      $error("pp_slow_div: SLOW_DIV must be even and at least 4");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             cnt_q <= '0;
      else if (cnt_q == CW'(SLOW_DIV - 1))    cnt_q <= '0;
      else                                    cnt_q <= cnt_q + 1'b1;
   end

   assign lvl_o     = (cnt_q < CW'(HALF));
   assign tick_o    = (cnt_q == CW'(SLOW_DIV - 1));
   // reload window: current and following count both in the low half
   assign low_win_o = !lvl_o && !tick_o;

endmodule

// File: rtl/pp_clk_gate_ctrl.sv
module pp_clk_gate_ctrl #(
   parameter int SLOW_DIV = 8,
   parameter int SETTLE   = 4
)(
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   input  logic tick_i,
   input  logic low_win_i,
   input  logic slow_lvl_i,
   output logic bias_o,
   output logic fast_en_o,
   output logic slow_en_o
);

   if (SETTLE < 0) begin : g_bad_settle
      $error("pp_clk_gate_ctrl: SETTLE must not be negative");
   end

   logic ready;
   logic bias_q, fast_q, slow_q;

   if (SETTLE == 0) begin : g_nosettle
      assign ready = 1'b1;
   end else begin : g_settle
      localparam int SW      = (SETTLE > 1) ? $clog2(SETTLE) : 1;
      localparam int MIN_WT  = (SETTLE - 1) * SLOW_DIV + 1;
      localparam int WW      = $clog2(SETTLE * SLOW_DIV + 4) + 1;
      localparam int WMAX    = (1 << WW) - 1;

      logic [SW-1:0] cnt_q;
      logic          rdy_q;
      logic [WW-1:0] wait_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
            rdy_q <= 1'b0;
         end else if (!req_i) begin
            cnt_q <= '0;
            rdy_q <= 1'b0;
         end else if (!rdy_q && tick_i) begin
            if (cnt_q == SW'(SETTLE - 1)) rdy_q <= 1'b1;
            else                          cnt_q <= cnt_q + 1'b1;
         end
      end
      assign ready = rdy_q;

      // cycles spent requesting with the fast gate still shut
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                               wait_q <= '0;
         else if (!req_i)                          wait_q <= '0;
         else if (!fast_q && wait_q != WW'(WMAX))  wait_q <= wait_q + 1'b1;
      end

      // R7
      settle_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(fast_q) |-> (wait_q >= WW'(MIN_WT)));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bias_q <= 1'b0;
         fast_q <= 1'b0;
         slow_q <= 1'b0;
      end else begin
         bias_q <= req_i || fast_q || slow_q;
         fast_q <= req_i && ready;
         if (low_win_i) slow_q <= req_i && ready;
      end
   end

   assign bias_o    = bias_q;
   assign fast_en_o = fast_q;
   assign slow_en_o = slow_q;

   // R6
   bias_under_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fast_q || slow_q) |-> bias_q);

   // R8
   slow_gate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(slow_q) |-> !slow_lvl_i);

endmodule

// File: rtl/pp_power_sequencer.sv
module pp_power_sequencer
   import pp_seq_pkg::*;
#(
   parameter int SLOW_DIV = 8,
   parameter int SETTLE   = 4
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  acq_start_i,
   input  logic                  acq_stop_i,
   input  logic                  conv_done_i,
   input  logic                  ro_start_i,
   input  logic                  ro_done_i,
   input  logic [PP_NUM_DOM-1:0] force_on_i,
   input  logic [PP_NUM_DOM-1:0] force_off_i,
   output logic [PP_NUM_DOM-1:0] pwr_en_o,
   output logic                  rx_bias_en_o,
   output logic                  fast_clk_en_o,
   output logic                  slow_clk_en_o,
   output logic                  slow_clk_o,
   output logic                  aux_rx_en_o,
   output logic                  ro_end_o,
   output logic [2:0]            phase_o
);

   pp_phase_e phase;
   logic      clk_req;
   logic      slow_lvl, slow_tick, slow_win;
   logic      slow_en;

   pp_phase_fsm i_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .acq_start_i (acq_start_i),
      .acq_stop_i  (acq_stop_i),
      .conv_done_i (conv_done_i),
      .ro_start_i  (ro_start_i),
      .ro_done_i   (ro_done_i),
      .phase_o     (phase),
      .ro_end_o    (ro_end_o)
   );

   pp_domain_ctrl #(.NUM_DOM(PP_NUM_DOM)) i_dom (
      .clk         (clk),
      .rst_n       (rst_n),
      .phase_i     (phase),
      .force_on_i  (force_on_i),
      .force_off_i (force_off_i),
      .en_o        (pwr_en_o),
      .aux_o       (aux_rx_en_o),
      .clk_req_o   (clk_req)
   );

   pp_slow_div #(.SLOW_DIV(SLOW_DIV)) i_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .lvl_o     (slow_lvl),
      .tick_o    (slow_tick),
      .low_win_o (slow_win)
   );

   pp_clk_gate_ctrl #(.SLOW_DIV(SLOW_DIV), .SETTLE(SETTLE)) i_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_i      (clk_req),
      .tick_i     (slow_tick),
      .low_win_i  (slow_win),
      .slow_lvl_i (slow_lvl),
      .bias_o     (rx_bias_en_o),
      .fast_en_o  (fast_clk_en_o),
      .slow_en_o  (slow_en)
   );

   assign slow_clk_en_o = slow_en;
   assign slow_clk_o    = slow_lvl && slow_en;
   assign phase_o       = phase;

   // R10
   sleep_no_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(phase == PH_SLEEP) && phase == PH_SLEEP && !force_on_i[DOM_DIG]
       && $past(!force_on_i[DOM_DIG])) |=> !fast_clk_en_o);

endmodule

// File: tb/test_pp_power_sequencer.sv
module test_pp_power_sequencer;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       acq_start, acq_stop, conv_done, ro_start, ro_done;
   logic [3:0] fon, foff;
   logic [3:0] pwr_en;
   logic       bias, fast_en, slow_en, slow_clk, aux, ro_end;
   logic [2:0] phase;

   int total = 0;
   int bad   = 0;
   bit done  = 0;
   int mph   = 0;

   always #5 clk = ~clk;

   pp_power_sequencer i_pp_power_sequencer (
      .clk(clk), .rst_n(rst_n),
      .acq_start_i(acq_start), .acq_stop_i(acq_stop), .conv_done_i(conv_done),
      .ro_start_i(ro_start), .ro_done_i(ro_done),
      .force_on_i(fon), .force_off_i(foff),
      .pwr_en_o(pwr_en), .rx_bias_en_o(bias), .fast_clk_en_o(fast_en),
      .slow_clk_en_o(slow_en), .slow_clk_o(slow_clk), .aux_rx_en_o(aux),
      .ro_end_o(ro_end), .phase_o(phase)
   );

   function automatic logic [3:0] map_of(int ph);
      case (ph)
         1: return 4'b1101;
         2: return 4'b1010;
         4: return 4'b1000;
         default: return 4'b0000;
      endcase
   endfunction

   function automatic logic [3:0] eff_of(int ph, logic [3:0] on, logic [3:0] off);
      return ~off & (on | map_of(ph));
   endfunction

   function automatic logic req_of(int ph, logic [3:0] on, logic [3:0] off);
      return !off[3] && (on[3] || ph == 1 || ph == 2 || ph == 4);
   endfunction

   function automatic int next_ph(int ph, int ev);
      // ev: 0 acq_start, 1 acq_stop, 2 conv_done, 3 ro_start, 4 ro_done
      if (ph == 0 && ev == 0) return 1;
      if (ph == 0 && ev == 3) return 4;
      if (ph == 1 && ev == 1) return 2;
      if (ph == 2 && ev == 2) return 3;
      if (ph == 3 && ev == 3) return 4;
      if (ph == 4 && ev == 4) return 0;
      return ph;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wait_n(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic fire(int ev);
      @(negedge clk);
      case (ev)
         0: acq_start = 1'b1;
         1: acq_stop  = 1'b1;
         2: conv_done = 1'b1;
         3: ro_start  = 1'b1;
         default: ro_done = 1'b1;
      endcase
      @(negedge clk);
      {acq_start, acq_stop, conv_done, ro_start, ro_done} = '0;
      mph = next_ph(mph, ev);
   endtask

   task automatic count_rises(int n, output int rises);
      logic prev;
      rises = 0;
      prev  = slow_clk;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (slow_clk && !prev) rises++;
         prev = slow_clk;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int r;
      logic [3:0] exp_en;
      void'($urandom(32'h1DE5_7A11));
      rst_n = 1'b0;
      {acq_start, acq_stop, conv_done, ro_start, ro_done} = '0;
      fon = '0; foff = '0;
      wait_n(3);
      // R1 during reset
      check("R1 phase in reset", phase, 0);
      check("R1 enables in reset", {pwr_en, bias, fast_en, slow_en, aux, ro_end}, 0);
      rst_n = 1'b1;
      wait_n(3);
      check("R1 enables after reset", {pwr_en, bias, fast_en, slow_en, aux, ro_end, slow_clk}, 0);

      // R10 stray events in idle
      fire(2); fire(4); fire(1); wait_n(2);
      check("R10 idle ignores stray", phase, 0);
      check("R10 idle enables stay off", {pwr_en, bias}, 0);

      // R2 R3 R5 R6 acquisition
      fire(0); wait_n(2);
      check("R2 acquire phase", phase, 1);
      check("R3 acquire map", pwr_en, 4'b1101);
      check("R5 aux on in acquire", aux, 1);
      check("R6 bias on request", bias, 1);
      wait_n(6);
      check("R7 fast gate still shut", {fast_en, slow_en}, 0);
      wait_n(52);
      check("R7 clocks open", {fast_en, slow_en}, 2'b11);
      count_rises(64, r);
      check("R8 slow clock rises", r, 8);

      // R10 readout start during acquire ignored
      fire(3); wait_n(2);
      check("R10 acquire ignores ro_start", phase, 1);
      check("R10 acquire enables unchanged", pwr_en, 4'b1101);

      fire(1); wait_n(2);
      check("R2 convert phase", phase, 2);
      check("R3 convert map", pwr_en, 4'b1010);
      check("R5 aux off in convert", aux, 0);

      fire(2); wait_n(20);
      check("R2 sleep phase", phase, 3);
      check("R3 sleep map", pwr_en, 0);
      check("R6 clocks and bias off in sleep", {bias, fast_en, slow_en}, 0);
      count_rises(32, r);
      check("R8 gated slow clock silent", r, 0);

      fire(3); wait_n(2);
      check("R2 readout phase", phase, 4);
      check("R3 readout map", pwr_en, 4'b1000);
      check("R6 bias on for readout", bias, 1);
      wait_n(58);
      check("R7 clocks open for readout", {fast_en, slow_en}, 2'b11);

      fire(4);
      check("R9 ro_end pulse", ro_end, 1);
      check("R9 back to idle", phase, 0);
      @(negedge clk);
      check("R9 ro_end single cycle", ro_end, 0);

      // R4 R5 forcing
      fon = 4'b1111; wait_n(3);
      check("R4 force on all", pwr_en, 4'b1111);
      check("R5 aux off outside acquire", aux, 0);
      foff = 4'b0001; wait_n(3);
      check("R4 force off wins", pwr_en, 4'b1110);
      fire(0); wait_n(2);
      check("R5 aux off when analogue forced off", aux, 0);
      foff = 4'b1000; fon = 4'b0000; wait_n(20);
      check("R6 digital force off drops clocks", {bias, fast_en, slow_en}, 0);
      check("R4 digital forced off in acquire", pwr_en, 4'b0101);
      foff = 4'b0000;
      fire(1); fire(2); fire(3); fire(4); wait_n(20);
      check("R2 cleanup idle", phase, 0);

      // random mix
      for (int it = 0; it < 300; it++) begin
         if ($urandom_range(7) == 0) begin
            fon  = 4'($urandom);
            foff = 4'($urandom & $urandom & $urandom);
         end
         fire($urandom_range(4));
         wait_n(20);
         exp_en = eff_of(mph, fon, foff);
         check("R2 random phase", phase, mph);
         check("R3 R4 random enables", pwr_en, exp_en);
         check("R5 random aux", aux, exp_en[0] && mph == 1);
         check("R6 random bias", bias, req_of(mph, fon, foff));
      end

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule